// File: doc/BRIEF.md
# RTC Status and Event Flag Register

This block is the 32-bit status word of a real-time clock. Its flags hold events until software clears them: two tamper detects, a time-stamp capture, a time-stamp overflow, an alarm-0 match and a pending smooth-calibration update. It also holds the initialization-mode control bit, a shadow-sync flag, and registered copies of four status inputs. The calendar, the alarm comparator, the tamper filters, the calibration datapath and the unlock-key logic sit outside the block. They reach it only as single-cycle strobes and level inputs.

Software writes the register only as a whole 32-bit word. Event flags are cleared by writing 0 to their bit. Writing 1 to a flag bit leaves it unchanged. The flag byte (bits 14:8) can always be cleared. Every other writable bit needs `unlocked_i` high. Two asynchronous active-low resets are provided. The backup-domain reset loads the full reset value. The system reset clears only the initialization and sync bits.

Top module: `rtc_stat_reg`

## Requirements
- R1: While `bkp_rst_ni` is low, `rd_data_o` reads 0x0000_0007.
- R2: A low `rst_ni` clears bits 7, 6 and 5. Every other bit keeps its value and still updates from its own events.
- R3: A one-cycle pulse on `tamp1_det_i`, `tamp0_det_i` or `alrm_match_i` sets bit 14, 13 or 8 respectively. The bit reads 1 after the next clock edge.
- R4: A pulse on `ts_evt_i` sets bit 11. A pulse on `ts_evt_i` while bit 11 already reads 1 also sets bit 12.
- R5: A word write clears each of bits 14, 13, 12, 11 and 8 whose data bit is 0, whatever `unlocked_i` is. A data bit of 1 leaves that flag unchanged.
- R6: When a set strobe and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R7: With `unlocked_i` high, a word write loads bit 7 (INITM) from data bit 7 and clears bit 5 (sync flag) when data bit 5 is 0. With `unlocked_i` low, both bits ignore writes.
- R8: Bit 16 sets on `cal_wr_i` only while bit 7 is 0. It clears on `cal_done_i`, and set takes priority over clear. Writes have no effect on bit 16.
- R9: A write with `wr_size_i` other than 2'b10 (word) changes no bit.
- R10: Bits 31:17, 15, 10 and 9 always read 0. Bits 2 and 1 always read 1.
- R11: Bits 6, 4, 3 and 0 show `init_ready_i`, `year_cfg_i`, `shift_pend_i` and `alrm_wr_ok_i` as sampled on the previous clock edge. A pulse on `sync_evt_i` sets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| bkp_rst_ni | input | 1 | Backup-domain reset, async, active low |
| rst_ni | input | 1 | System reset, async, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_size_i | input | 2 | Access size, 2'b10 = word |
| wr_data_i | input | 32 | Write data |
| unlocked_i | input | 1 | Write protection lifted |
| rd_data_o | output | 32 | Register read value |
| tamp1_det_i | input | 1 | Tamper-1 detect strobe |
| tamp0_det_i | input | 1 | Tamper-0 detect strobe |
| ts_evt_i | input | 1 | Time-stamp event strobe |
| alrm_match_i | input | 1 | Alarm-0 match strobe |
| cal_wr_i | input | 1 | Calibration register written |
| cal_done_i | input | 1 | Calibration applied |
| sync_evt_i | input | 1 | Shadow registers synchronized |
| init_ready_i | input | 1 | Initialization allowed status |
| year_cfg_i | input | 1 | Year configured status |
| shift_pend_i | input | 1 | Shift operation pending status |
| alrm_wr_ok_i | input | 1 | Alarm-0 writable status |

## Verification
All state is registered, and the read path is combinational from those registers. Every strobe, write or status input is therefore visible on `rd_data_o` exactly one clock edge after it is presented. The one exception is a reset, which acts as soon as it asserts. The bench drives stimulus on the falling edge. Its behavioural model updates on the rising edge, and on the asynchronous reset edges. The full read word is compared with the model on the next falling edge, so every result is checked in the cycle it falls due.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [1:0]  SIZE_WORD = 2'b10;
  localparam int BIT_SCP  = 16;
  localparam int BIT_TSOV = 12;
  localparam int BIT_INIM = 7;
  localparam int BIT_INIF = 6;
  localparam int BIT_RSY  = 5;
  localparam int BIT_YCF  = 4;
  localparam int BIT_SHP  = 3;
  localparam int BIT_AWOK = 0;
  localparam logic [REG_W-1:0] RSVD_ONES = 32'h0000_0006;
  // event flags sharing write-0-clear: tamper1, tamper0, time-stamp, alarm0
  localparam int N_EVT  = 4;
  localparam int EVT_TS = 2;
  localparam int EVT_POS [N_EVT] = '{14, 13, 11, 8};
  // mirrored status inputs: {init_ready, year_cfg, shift_pend, alrm_wr_ok}
  localparam int N_MIR = 4;
endpackage

// File: rtl/rtc_stat_flag.sv
module rtc_stat_flag #(
  parameter logic RST_VAL = 1'b0,
  parameter bit   SYS_CLR = 1'b0
) (
  input  logic clk_i,
  input  logic bkp_rst_ni,
  input  logic sys_rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic rst_n;
  logic q;

  if (SYS_CLR) begin : g_sys
    assign rst_n = bkp_rst_ni & sys_rst_ni;
  end else begin : g_bkp
    assign rst_n = bkp_rst_ni;
  end

  // set has priority so no event is lost
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    set_i |=> q_o) else $error("set lost"); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o)) else $error("flag moved"); // R5
endmodule

// File: rtl/rtc_stat_mirror.sv
module rtc_stat_mirror #(
  parameter int unsigned W        = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] SYS_MSK = '0
) (
  input  logic         clk_i,
  input  logic         bkp_rst_ni,
  input  logic         sys_rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rst_n;
    logic q;
    assign rst_n = SYS_MSK[i] ? (bkp_rst_ni & sys_rst_ni) : bkp_rst_ni;
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[i];
      else        q <= d_i[i];
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/rtc_stat_reg.sv
module rtc_stat_reg
  import rtc_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             bkp_rst_ni,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_size_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             unlocked_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             tamp1_det_i,
  input  logic             tamp0_det_i,
  input  logic             ts_evt_i,
  input  logic             alrm_match_i,
  input  logic             cal_wr_i,
  input  logic             cal_done_i,
  input  logic             sync_evt_i,
  input  logic             init_ready_i,
  input  logic             year_cfg_i,
  input  logic             shift_pend_i,
  input  logic             alrm_wr_ok_i
);
  logic             wr_word, wr_prot, all_rst_n;
  logic [N_EVT-1:0] evt_set, evt_q;
  logic             tsov_q, scp_q, rsy_q, initm_q;
  logic [N_MIR-1:0] mir_q;
  logic [REG_W-1:0] rd;

  assign wr_word   = wr_en_i && (wr_size_i == SIZE_WORD);
  assign wr_prot   = wr_word && unlocked_i;
  assign all_rst_n = bkp_rst_ni & rst_ni;
  assign evt_set   = {alrm_match_i, ts_evt_i, tamp0_det_i, tamp1_det_i};

  // flag byte: clearable regardless of write protection
  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    rtc_stat_flag #(.RST_VAL(1'b0), .SYS_CLR(1'b0)) u_flag (
      .clk_i, .bkp_rst_ni, .sys_rst_ni(rst_ni),
      .set_i(evt_set[i]), .clr_i(wr_word && !wr_data_i[EVT_POS[i]]),
      .q_o(evt_q[i]));
  end

  rtc_stat_flag #(.RST_VAL(1'b0), .SYS_CLR(1'b0)) u_tsov (
    .clk_i, .bkp_rst_ni, .sys_rst_ni(rst_ni),
    .set_i(ts_evt_i && evt_q[EVT_TS]), .clr_i(wr_word && !wr_data_i[BIT_TSOV]),
    .q_o(tsov_q));

  rtc_stat_flag #(.RST_VAL(1'b0), .SYS_CLR(1'b0)) u_scp (
    .clk_i, .bkp_rst_ni, .sys_rst_ni(rst_ni),
    .set_i(cal_wr_i && !initm_q), .clr_i(cal_done_i),
    .q_o(scp_q));

  rtc_stat_flag #(.RST_VAL(1'b0), .SYS_CLR(1'b1)) u_rsy (
    .clk_i, .bkp_rst_ni, .sys_rst_ni(rst_ni),
    .set_i(sync_evt_i), .clr_i(wr_prot && !wr_data_i[BIT_RSY]),
    .q_o(rsy_q));

  always_ff @(posedge clk_i or negedge all_rst_n) begin
    if (!all_rst_n)   initm_q <= 1'b0;
    else if (wr_prot) initm_q <= wr_data_i[BIT_INIM];
  end

  rtc_stat_mirror #(.W(N_MIR), .RST_VAL(4'b0001), .SYS_MSK(4'b1000)) u_mir (
    .clk_i, .bkp_rst_ni, .sys_rst_ni(rst_ni),
    .d_i({init_ready_i, year_cfg_i, shift_pend_i, alrm_wr_ok_i}),
    .q_o(mir_q));

  always_comb begin
    rd = RSVD_ONES;
    for (int i = 0; i < N_EVT; i++) rd[EVT_POS[i]] = evt_q[i];
    rd[BIT_TSOV] = tsov_q;
    rd[BIT_SCP]  = scp_q;
    rd[BIT_INIM] = initm_q;
    rd[BIT_RSY]  = rsy_q;
    rd[BIT_INIF] = mir_q[3];
    rd[BIT_YCF]  = mir_q[2];
    rd[BIT_SHP]  = mir_q[1];
    rd[BIT_AWOK] = mir_q[0];
  end

  assign rd_data_o = rd;

  AST_TS_OVERFLOW: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni)
    (ts_evt_i && rd_data_o[EVT_POS[EVT_TS]]) |=> rd_data_o[BIT_TSOV])
    else $error("overflow missed"); // R4
  AST_LOCKED_INITM: assert property (@(posedge clk_i) disable iff (!all_rst_n)
    (!unlocked_i || !wr_word) |=> $stable(rd_data_o[BIT_INIM]))
    else $error("protected bit written"); // R7
  AST_NARROW_IGN: assert property (@(posedge clk_i) disable iff (!all_rst_n)
    (wr_en_i && wr_size_i != SIZE_WORD && !sync_evt_i) |=> $stable(rd_data_o[BIT_RSY]))
    else $error("narrow write took effect"); // R9
  AST_SCP_INIT: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni)
    (rd_data_o[BIT_INIM] && !rd_data_o[BIT_SCP]) |=> !rd_data_o[BIT_SCP])
    else $error("calibration pending in init mode"); // R8
  AST_MIRROR: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni)
    1'b1 |=> rd_data_o[BIT_YCF] == $past(year_cfg_i))
    else $error("status mirror late"); // R11
endmodule

// File: tb/rtc_stat_reg_tb.sv
module rtc_stat_reg_tb;
  logic        clk = 1'b0;
  logic        bkp_rst_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, unl = 0;
  logic [1:0]  wr_size = 2'b10;
  logic [31:0] wd = '0;
  logic        t1 = 0, t0 = 0, ts = 0, alm = 0, calw = 0, cald = 0, syn = 0;
  logic        s_init = 0, s_year = 0, s_shift = 0, s_awok = 1;
  logic [31:0] rd;
  logic [31:0] m = 32'h7;
  int          checks = 0, errors = 0;
  string       cur_req = "R1";

  always #2.5 clk = ~clk;

  rtc_stat_reg u_dut (
    .clk_i(clk), .bkp_rst_ni(bkp_rst_n), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_size_i(wr_size), .wr_data_i(wd), .unlocked_i(unl),
    .rd_data_o(rd), .tamp1_det_i(t1), .tamp0_det_i(t0), .ts_evt_i(ts),
    .alrm_match_i(alm), .cal_wr_i(calw), .cal_done_i(cald), .sync_evt_i(syn),
    .init_ready_i(s_init), .year_cfg_i(s_year), .shift_pend_i(s_shift),
    .alrm_wr_ok_i(s_awok));

  function automatic logic [31:0] step(input logic [31:0] c);
    logic [31:0] n = c;
    logic ww = wr_en && wr_size == 2'b10;
    logic [3:0] ev = {t1, t0, ts, alm};
    int pos [4] = '{14, 13, 11, 8};
    for (int i = 0; i < 4; i++)
      if (ev[3-i]) n[pos[i]] = 1'b1;
      else if (ww && !wd[pos[i]]) n[pos[i]] = 1'b0;
    if (ts && c[11]) n[12] = 1'b1;
    else if (ww && !wd[12]) n[12] = 1'b0;
    if (calw && !c[7]) n[16] = 1'b1;
    else if (cald) n[16] = 1'b0;
    if (ww && unl) n[7] = wd[7];
    if (syn) n[5] = 1'b1;
    else if (ww && unl && !wd[5]) n[5] = 1'b0;
    n[6] = s_init; n[4] = s_year; n[3] = s_shift; n[0] = s_awok;
    return n;
  endfunction

  always @(posedge clk or negedge bkp_rst_n or negedge rst_n) begin
    if (!bkp_rst_n)  m = 32'h7;
    else if (!rst_n) m = (clk ? step(m) : m) & ~32'hE0;
    else             m = step(m);
  end

  task automatic check();
    checks++;
    if (rd !== m) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", cur_req, rd, m);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check();
      {wr_en, t1, t0, ts, alm, calw, cald, syn} = '0;
      wr_size = 2'b10;
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic u, input logic [1:0] sz = 2'b10);
    wr_en = 1; wd = d; unl = u; wr_size = sz;
  endtask

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1"; check(); cyc(2);
    if (rd !== 32'h7) begin errors++; $display("FAIL R1: rd=%h expected=00000007", rd); end
    checks++;
    bkp_rst_n = 1; cyc(1); rst_n = 1; cyc(1);
    cur_req = "R11";
    s_init = 1; s_year = 1; s_shift = 1; s_awok = 0; cyc(1);
    s_year = 0; syn = 1; cyc(2);
    cur_req = "R3";
    t1 = 1; cyc(1); t0 = 1; cyc(1); alm = 1; cyc(1);
    cur_req = "R5";
    wr(32'hFFFF_FFFF, 0); cyc(1);
    wr(~(32'h1 << 13), 0); cyc(1);
    wr(32'h0000_0000, 0); cyc(1);
    cur_req = "R4";
    ts = 1; cyc(1); ts = 1; cyc(1);
    wr(~(32'h1 << 11), 0); cyc(1);
    ts = 1; cyc(1);
    wr(32'h0, 1); cyc(1);
    cur_req = "R6";
    t1 = 1; wr(32'h0, 0); cyc(1);
    ts = 1; wr(32'h0, 0); cyc(1);
    cur_req = "R7";
    syn = 1; cyc(1);
    wr(32'h80, 0); cyc(1);
    wr(32'h0, 0); cyc(1);
    wr(32'hA0, 1); cyc(1);
    wr(32'h80, 1); cyc(1);
    cur_req = "R8";
    calw = 1; cyc(1);
    wr(32'h0, 1); cyc(1);
    calw = 1; cyc(1);
    wr(32'hFFFE_FFFF, 1); cyc(1);
    calw = 1; cald = 1; cyc(1);
    cald = 1; cyc(1);
    cur_req = "R9";
    alm = 1; syn = 1; cyc(1);
    wr(32'h0, 1, 2'b01); cyc(1);
    wr(32'h0, 1, 2'b00); cyc(1);
    wr(32'h0, 1, 2'b11); cyc(1);
    cur_req = "R10";
    wr(32'hFFFF_FFFF, 1); cyc(1);
    wr(32'h0, 1); cyc(1);
    cur_req = "R2";
    t0 = 1; ts = 1; syn = 1; wr(32'hFFFF_FFFF, 1); cyc(1);
    calw = 1; cyc(1);
    rst_n = 0; cyc(1);
    alm = 1; cyc(1);
    rst_n = 1; cyc(2);
    cur_req = "R3";
    for (int k = 0; k < 400; k++) begin
      {t1, t0, ts, alm} = 4'($urandom);
      calw = ($urandom % 4) == 0; cald = ($urandom % 4) == 0; syn = ($urandom % 5) == 0;
      {s_init, s_year, s_shift, s_awok} = 4'($urandom);
      if ($urandom % 2) wr($urandom, 1'($urandom), 2'($urandom));
      if (k == 200) bkp_rst_n = 0;
      if (k == 203) bkp_rst_n = 1;
      cyc(1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule